// File: doc/BRIEF.md
# Performance Monitor with Shared Control Word

This block counts hardware events for software profiling. It has three 32-bit counters: one that counts clock cycles and two that count events. Each event counter picks one line of an event pulse vector by an 8-bit code. A single control word holds the whole configuration and status of the unit: the run bit, a cycle prescale option, one-shot clear strobes, the interrupt enables, the overflow flags and both event codes. Because the flags live in that same word, software can read the word, handle the overflows, and write the same value back. That write-back clears exactly the flags that were set.

A simple register bus gives access to the unit. The write is one cycle wide, and the read data is a combinational function of the address. The byte addresses are: the control word at 0x0, the cycle counter at 0x4, event counter 0 at 0x8 and event counter 1 at 0xC. Software loads a counter with a start value so that the counter overflows after a chosen number of events. The single interrupt output tells software that an enabled counter has wrapped.

Top module: `perf_monitor`

## Requirements
- R1: After reset the control word reads 0x0FFFF000, with both event codes at 0xFF and every other field 0. All counters read 0 and irq is low.
- R2: A write to address 0x4, 0x8 or 0xC loads the cycle counter, event counter 0 or event counter 1. A read at that address returns the counter value.
- R3: While control bit 0 (run) is clear, no counter advances, whatever the event inputs do.
- R4: While run is set and control bit 3 is clear, the cycle counter advances by one on every clock.
- R5: While run and control bit 3 are both set, the cycle counter advances once every 64 clocks. The first step comes on the 64th clock after the mode takes effect.
- R6: Event counter 0 takes its code from bits 19:12, and event counter 1 takes its code from bits 27:20. A counter advances on each clock in which the event input indexed by its code is high. Code 0xFF, or any code with no input wired to it, never advances the counter.
- R7: Writing 1 to control bit 1 clears both event counters, and writing 1 to bit 2 clears the cycle counter. The clear takes effect at that write's clock edge. Both bits always read back as 0.
- R8: A counter that steps from 0xFFFFFFFF to 0 sets its overflow flag. Event counter 0 uses flag bit 8, event counter 1 uses bit 9 and the cycle counter uses bit 10.
- R9: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. If a counter overflows in the same cycle as a clearing write to its flag, the flag stays set.
- R10: irq is high exactly when some flag is set and its enable is also set. The enable for event counter 0 is bit 4, for event counter 1 is bit 5, and for the cycle counter is bit 6.
- R11: Control bits 7, 11 and 31:28 are not stored and always read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| evt_in | input | N_EVT | Event pulse lines, indexed by event code |
| irq | output | 1 | Interrupt request |

## Verification
The overflow flags are kept in state that is shared with the configuration. A wrong flag therefore shows up at once in two places: the control word read and irq. A flag that is lost or wrongly set is visible in the cycle after the wrap. A mistake in the event-select or prescale path only shows in the counter value. It needs a known number of pulses or clocks before a read, and a prescale off-by-one becomes visible only at the 64th clock. So the checks compare exact counts at exact cycles, and a flag that is cleared by mistake in the same cycle as an overflow is tested directly.

// File: rtl/perf_mon_pkg.sv
package perf_mon_pkg;

    localparam int REG_W      = 32;
    localparam int NUM_CNT    = 3;      // 0: event 0, 1: event 1, 2: cycles
    localparam int CYC_IDX    = 2;
    localparam int SEL_W      = 8;
    localparam logic [SEL_W-1:0] SEL_UNUSED = 8'hFF;

    // Control word bit positions (software decodes these)
    localparam int B_RUN      = 0;
    localparam int B_EVT_CLR  = 1;
    localparam int B_CYC_CLR  = 2;
    localparam int B_PRESC    = 3;
    localparam int B_IE       = 4;
    localparam int B_OVF      = 8;
    localparam int B_SEL0     = 12;
    localparam int B_SEL1     = 20;

    typedef struct packed {
        logic               run;
        logic               presc;
        logic [NUM_CNT-1:0] ie;
        logic [NUM_CNT-1:0] ovf;
        logic [SEL_W-1:0]   sel0;
        logic [SEL_W-1:0]   sel1;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{run: 1'b0, presc: 1'b0, ie: '0, ovf: '0,
                                   sel0: SEL_UNUSED, sel1: SEL_UNUSED};

    // Register slot (address bits 3:2) to counter index; slot 0 is control.
    function automatic logic [1:0] cnt_of_slot(input logic [1:0] slot);
        case (slot)
            2'd1:    return 2'd2;
            2'd2:    return 2'd0;
            2'd3:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[B_RUN]                   = c.run;
        w[B_PRESC]                 = c.presc;
        w[B_IE  +: NUM_CNT]        = c.ie;
        w[B_OVF +: NUM_CNT]        = c.ovf;
        w[B_SEL0 +: SEL_W]         = c.sel0;
        w[B_SEL1 +: SEL_W]         = c.sel1;
        return w;
    endfunction

endpackage

// File: rtl/perf_evt_pick.sv
module perf_evt_pick
    import perf_mon_pkg::*;
#(
    parameter int N_EVT = 16
) (
    input  logic [N_EVT-1:0] evt_in,
    input  logic [SEL_W-1:0] code,
    output logic             hit
);

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < N_EVT; i++) begin
            if (code == SEL_W'(i) && code != SEL_UNUSED && evt_in[i])
                hit = 1'b1;
        end
    end

endmodule

// File: rtl/perf_prescale.sv
module perf_prescale #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] div_d, div_q;

    always_comb begin
        tick  = run && (div_q == PW'(DIV - 1));
        div_d = div_q;
        if (!run)
            div_d = '0;
        else if (tick)
            div_d = '0;
        else
            div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

endmodule

// File: rtl/perf_counter.sv
module perf_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         wrap
);

    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        wrap  = 1'b0;
        if (clr) begin
            val_d = '0;
        end else if (load) begin
            val_d = load_val;
        end else if (inc) begin
            val_d = val_q + 1'b1;
            wrap  = &val_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign value = val_q;

endmodule

// File: rtl/perf_monitor.sv
module perf_monitor
    import perf_mon_pkg::*;
#(
    parameter int N_EVT     = 16,
    parameter int PRESC_DIV = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [3:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic [N_EVT-1:0] evt_in,
    output logic             irq
);

    localparam int N_SEL = NUM_CNT - 1;

    ctrl_t              ctrl_d, ctrl_q;
    logic [1:0]         slot;
    logic               ctrl_wr;
    logic               evt_clr, cyc_clr;
    logic               presc_tick;
    logic [SEL_W-1:0]   sel_code [N_SEL];
    logic [N_SEL-1:0]   evt_hit;
    logic [REG_W-1:0]   cnt_val  [NUM_CNT];
    logic [NUM_CNT-1:0] cnt_wrap, cnt_inc, cnt_load, cnt_clr;

    assign slot    = bus_addr[3:2];
    assign ctrl_wr = bus_wr && (slot == 2'd0);
    assign evt_clr = ctrl_wr && bus_wdata[B_EVT_CLR];
    assign cyc_clr = ctrl_wr && bus_wdata[B_CYC_CLR];

    assign sel_code[0] = ctrl_q.sel0;
    assign sel_code[1] = ctrl_q.sel1;

    generate
        for (genvar s = 0; s < N_SEL; s++) begin : g_pick
            perf_evt_pick #(.N_EVT(N_EVT)) u_pick (
                .evt_in (evt_in),
                .code   (sel_code[s]),
                .hit    (evt_hit[s])
            );
        end
    endgenerate

    perf_prescale #(.DIV(PRESC_DIV)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl_q.run && ctrl_q.presc),
        .tick  (presc_tick)
    );

    generate
        for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
            if (c == CYC_IDX) begin : g_cyc
                assign cnt_inc[c] = ctrl_q.run && (ctrl_q.presc ? presc_tick : 1'b1);
                assign cnt_clr[c] = cyc_clr;
            end else begin : g_evt
                assign cnt_inc[c] = ctrl_q.run && evt_hit[c];
                assign cnt_clr[c] = evt_clr;
            end
            assign cnt_load[c] = bus_wr && (slot != 2'd0) && (cnt_of_slot(slot) == 2'(c));

            perf_counter #(.W(REG_W)) u_cnt (
                .clk      (clk),
                .rst_n    (rst_n),
                .clr      (cnt_clr[c]),
                .load     (cnt_load[c]),
                .load_val (bus_wdata),
                .inc      (cnt_inc[c]),
                .value    (cnt_val[c]),
                .wrap     (cnt_wrap[c])
            );
        end
    endgenerate

    // Next control word: fields from a write, flags cleared by written ones,
    // and a wrap in the same cycle always wins over the clear.
    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr) begin
            ctrl_d.run   = bus_wdata[B_RUN];
            ctrl_d.presc = bus_wdata[B_PRESC];
            ctrl_d.ie    = bus_wdata[B_IE   +: NUM_CNT];
            ctrl_d.sel0  = bus_wdata[B_SEL0 +: SEL_W];
            ctrl_d.sel1  = bus_wdata[B_SEL1 +: SEL_W];
            ctrl_d.ovf   = ctrl_q.ovf & ~bus_wdata[B_OVF +: NUM_CNT];
        end
        ctrl_d.ovf = ctrl_d.ovf | cnt_wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= CTRL_RST;
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        case (slot)
            2'd0:    bus_rdata = pack_ctrl(ctrl_q);
            default: bus_rdata = cnt_val[cnt_of_slot(slot)];
        endcase
    end

    assign irq = |(ctrl_q.ovf & ctrl_q.ie);

endmodule

// File: rtl/perf_monitor_chk.sv
module perf_monitor_chk
    import perf_mon_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [3:0]       bus_addr,
    input logic [REG_W-1:0] bus_rdata,
    input logic             irq,
    input ctrl_t            ctrl_q,
    input logic [REG_W-1:0] cnt_val [NUM_CNT]
);

    assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[3:2] == 2'd0) |->
        (bus_rdata[31:28] == 4'd0 && bus_rdata[11] == 1'b0 && bus_rdata[7] == 1'b0
         && bus_rdata[2:1] == 2'd0));

    assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_wr) |=> irq);

    assert_presc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.run && ctrl_q.presc && !bus_wr) |=>
        (32'(cnt_val[CYC_IDX] - $past(cnt_val[CYC_IDX])) <= 32'd1));

    generate
        for (genvar c = 0; c < NUM_CNT; c++) begin : g_chk
            assert_wrap_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (cnt_val[c] == '1 && !bus_wr && ctrl_q.run) |=>
                (cnt_val[c] != '0 || ctrl_q.ovf[c]));

            assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (ctrl_q.ovf[c] && !bus_wr) |=> ctrl_q.ovf[c]);

            assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (!ctrl_q.run && !bus_wr) |=> $stable(cnt_val[c]));
        end
    endgenerate

endmodule

bind perf_monitor perf_monitor_chk u_chk (.*);

// File: tb/perf_monitor_test.sv
module perf_monitor_test;

    localparam int N_EVT = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic [3:0]       bus_addr = 4'h0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [N_EVT-1:0] evt_in = '0;
    logic             irq;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    perf_monitor #(.N_EVT(N_EVT), .PRESC_DIV(64)) uut (
        .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .evt_in, .irq
    );

    typedef struct packed {
        logic [7:0]  code;
        logic [15:0] pat;
        logic [7:0]  cyc;
        logic        run;
        logic [31:0] exp_cnt;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h07, 16'h0080, 8'd5, 1'b1, 32'd5},
        '{8'h05, 16'h0040, 8'd4, 1'b1, 32'd0},
        '{8'hFF, 16'hFFFF, 8'd6, 1'b1, 32'd0},
        '{8'h0B, 16'h0800, 8'd9, 1'b1, 32'd9},
        '{8'h00, 16'h0001, 8'd3, 1'b1, 32'd3},
        '{8'h20, 16'hFFFF, 8'd4, 1'b1, 32'd0},
        '{8'h07, 16'h0080, 8'd7, 1'b0, 32'd0},
        '{8'h0A, 16'h0400, 8'd2, 1'b1, 32'd2}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'h0, v); check("R1 ctrl", v, 32'h0FFFF000);
        rd(4'h4, v); check("R1 cycle cnt", v, 32'h0);
        rd(4'h8, v); check("R1 cnt0", v, 32'h0);
        rd(4'hC, v); check("R1 cnt1", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // Table: event selection (R6) and run gating (R3)
        for (int k = 0; k < NV; k++) begin
            wr(4'h0, 32'h0FFFF000);
            wr(4'h8, 32'h0);
            wr(4'h0, {4'h0, 8'hFF, VECS[k].code, 11'h0, VECS[k].run});
            evt_in = VECS[k].pat;
            repeat (int'(VECS[k].cyc)) @(negedge clk);
            evt_in = '0;
            rd(4'h8, v);
            check(VECS[k].run ? "R6 event count" : "R3 halted count", v, VECS[k].exp_cnt);
        end

        // R2 counter load/read
        wr(4'h0, 32'h0FFFF000);
        wr(4'h4, 32'h12345678);
        rd(4'h4, v); check("R2 cycle load", v, 32'h12345678);
        wr(4'hC, 32'hCAFE0001);
        rd(4'hC, v); check("R2 cnt1 load", v, 32'hCAFE0001);

        // R4 cycle counting every clock
        wr(4'h4, 32'h0);
        wr(4'h0, 32'h0FFFF001);
        repeat (10) @(negedge clk);
        rd(4'h4, v); check("R4 cycle count", v, 32'd10);

        // R5 prescaled cycle counting
        wr(4'h0, 32'h0FFFF000);
        wr(4'h4, 32'h0);
        wr(4'h0, 32'h0FFFF009);
        repeat (63) @(negedge clk);
        rd(4'h4, v); check("R5 before 64th clock", v, 32'd0);
        @(negedge clk);
        rd(4'h4, v); check("R5 at 64th clock", v, 32'd1);

        // R7 clear strobes
        wr(4'h8, 32'h55);
        wr(4'hC, 32'h66);
        wr(4'h0, 32'h0FFFF004);
        rd(4'h4, v); check("R7 cycle cleared", v, 32'h0);
        rd(4'h8, v); check("R7 cnt0 kept", v, 32'h55);
        rd(4'h0, v); check("R7 strobe reads 0", v, 32'h0FFFF000);
        wr(4'h0, 32'h0FFFF002);
        rd(4'h8, v); check("R7 cnt0 cleared", v, 32'h0);
        rd(4'hC, v); check("R7 cnt1 cleared", v, 32'h0);

        // R8/R10 cycle counter overflow with interrupt enabled
        wr(4'h4, 32'hFFFFFFFE);
        wr(4'h0, 32'h0FFFF041);
        rd(4'h4, v); check("R8 pre-wrap", v, 32'hFFFFFFFE);
        @(negedge clk);
        check("R10 irq before wrap", {31'b0, irq}, 32'h0);
        @(negedge clk);
        rd(4'h4, v); check("R8 wrapped", v, 32'h0);
        rd(4'h0, v); check("R8 cycle flag", v, 32'h0FFFF441);
        check("R10 irq on wrap", {31'b0, irq}, 32'h1);
        wr(4'h0, 32'h0FFFF040);
        rd(4'h0, v); check("R9 write 0 keeps flag", v, 32'h0FFFF440);
        check("R10 irq held", {31'b0, irq}, 32'h1);
        wr(4'h0, 32'h0FFFF440);
        rd(4'h0, v); check("R9 write 1 clears flag", v, 32'h0FFFF040);
        check("R10 irq dropped", {31'b0, irq}, 32'h0);

        // R8/R10 event counter 1 overflow with interrupt masked
        wr(4'h0, 32'h0FFFF000);
        wr(4'hC, 32'hFFFFFFFF);
        wr(4'h0, 32'h007FF001);
        evt_in = 16'h0080;
        @(negedge clk);
        evt_in = '0;
        rd(4'hC, v); check("R8 cnt1 wrapped", v, 32'h0);
        rd(4'h0, v); check("R8 cnt1 flag", v, 32'h007FF201);
        check("R10 masked irq", {31'b0, irq}, 32'h0);
        wr(4'h0, 32'h007FF021);
        check("R10 irq after enable", {31'b0, irq}, 32'h1);
        wr(4'h0, 32'h007FF200);
        check("R9 cnt1 flag cleared irq", {31'b0, irq}, 32'h0);

        // R9 overflow and clear in the same cycle: flag stays
        wr(4'h0, 32'h0FF07001);
        wr(4'h8, 32'hFFFFFFFF);
        @(negedge clk);
        evt_in = 16'h0080;
        bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h0FF07101;
        @(negedge clk);
        bus_wr = 1'b0;
        evt_in = '0;
        rd(4'h8, v); check("R9 cnt0 wrapped", v, 32'h0);
        rd(4'h0, v); check("R9 set wins over clear", v, 32'h0FF07101);
        wr(4'h0, 32'h0FF07100);
        rd(4'h0, v); check("R9 later clear", v, 32'h0FF07000);

        // R11 reserved bits
        wr(4'h0, 32'hF0000880);
        rd(4'h0, v); check("R11 reserved read 0", v, 32'h0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule